// File: doc/BRIEF.md
# Handshaked 256-bit Galois LFSR Word Generator

This block produces a stream of 256-bit pseudo-random words from a right-shifting Galois linear feedback shift register. After a synchronous, active-high reset, the register holds a fixed non-zero seed. Each cycle in which the request strobe `valid_i` is sampled high, the register moves forward by exactly one step.

On the next cycle the whole new register state appears on `data_o`, and `valid_o` is high for that cycle. There is no backpressure. A consumer that wants one word raises `valid_i` for one cycle and takes `data_o` when `valid_o` is high. A consumer that holds `valid_i` high for several cycles gets one fresh word per cycle. Between requests, `data_o` keeps the most recent word.

The width, the seed and the tap mask are parameters. The defaults give the 256-bit configuration described here.

Top module: `lfsr_word_gen`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the state is loaded with 0xDEADBEEFCAFEBABEFEEDFACEDECAFBAD1234567887654321ABCDEF010FEDCBA9. On the following cycle `data_o` shows that seed and `valid_o` is 0.
- R2: One step shifts the state right by one: new bit i equals old bit i+1 for i in 0..254, apart from the tap positions in R3. New bit 255 equals the old bit 0, which is the feedback bit.
- R3: When the feedback bit (old bit 0) is 1, new bits 254, 252, 251 and 246 are inverted after the shift. When it is 0, no bit is inverted.
- R4: When `valid_i` is high at a rising edge, `valid_o` is 1 in the next cycle and `data_o` equals the state after one step.
- R5: `valid_o` is 0 in every cycle whose preceding edge did not sample `valid_i` high, reset included.
- R6: A cycle with `valid_i` low does not advance the register. `data_o` keeps its previous value.
- R7: With `valid_i` high on consecutive edges, the register advances once per edge and `valid_o` stays 1. Each cycle shows the next successive state.
- R8: Reset is synchronous and takes priority over `valid_i`. A reset in the middle of a run returns the output to the seed with `valid_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Step request; one step per cycle sampled high |
| data_o | output | 256 | Current register state |
| valid_o | output | 1 | High for the cycle after a step request |

## Verification
The assertions check on every cycle:
- the one-cycle handshake;
- the hold of the word between requests;
- the move of the feedback bit into the top position;
- the full single-step relation between consecutive words;
- the reload of the seed after reset.

Only the bench scenarios can show that the bench's own reference model follows the exact sequence from the seed over many steps. They also cover the inversion of the four tap bits on a known word, and the priority of reset over a request during a back-to-back burst or a gapped request pattern.

// File: rtl/lfsr_gen_pkg.sv
package lfsr_gen_pkg;
  localparam int unsigned LFSR_W = 256;

  // Power-on seed of the register.
  localparam logic [LFSR_W-1:0] LFSR_SEED =
    256'hDEADBEEFCAFEBABEFEEDFACEDECAFBAD1234567887654321ABCDEF010FEDCBA9;

  // Bits of the right-shifted word that flip when the feedback bit is 1.
  localparam logic [LFSR_W-1:0] LFSR_TAPS =
    (256'd1 << 254) | (256'd1 << 252) | (256'd1 << 251) | (256'd1 << 246);
endpackage

// File: rtl/lfsr_gen_step.sv
// One Galois step, computed bit by bit.
module lfsr_gen_step #(
  parameter int unsigned     W    = lfsr_gen_pkg::LFSR_W,
  parameter logic [W-1:0]    TAPS = lfsr_gen_pkg::LFSR_TAPS
) (
  input  logic [W-1:0] cur_i,
  output logic         fb_o,
  output logic [W-1:0] nxt_o
);
  assign fb_o = cur_i[0];

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W-1) begin : g_top
      assign nxt_o[i] = fb_o ^ (fb_o & TAPS[i]);
    end else begin : g_mid
      assign nxt_o[i] = cur_i[i+1] ^ (fb_o & TAPS[i]);
    end
  end
endmodule

// File: rtl/lfsr_gen_core.sv
// State register plus the one-cycle valid flag.
module lfsr_gen_core #(
  parameter int unsigned  W    = lfsr_gen_pkg::LFSR_W,
  parameter logic [W-1:0] SEED = lfsr_gen_pkg::LFSR_SEED,
  parameter logic [W-1:0] TAPS = lfsr_gen_pkg::LFSR_TAPS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_i,
  output logic [W-1:0] state_o,
  output logic         fb_o,
  output logic         fresh_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_nxt;
  logic         fresh_q;

  lfsr_gen_step #(.W(W), .TAPS(TAPS)) step_i (
    .cur_i (state_q),
    .fb_o  (fb_o),
    .nxt_o (state_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= adv_i;
      if (adv_i) state_q <= state_nxt;
    end
  end

  assign state_o = state_q;
  assign fresh_o = fresh_q;
endmodule

// File: rtl/lfsr_word_gen.sv
module lfsr_word_gen #(
  parameter int unsigned  W    = lfsr_gen_pkg::LFSR_W,
  parameter logic [W-1:0] SEED = lfsr_gen_pkg::LFSR_SEED,
  parameter logic [W-1:0] TAPS = lfsr_gen_pkg::LFSR_TAPS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  output logic [W-1:0] data_o,
  output logic         valid_o
);
  // Named internal events for the checker.
  logic step_fire;
  logic fb_bit;

  assign step_fire = valid_i & ~rst;

  lfsr_gen_core #(.W(W), .SEED(SEED), .TAPS(TAPS)) core_i (
    .clk     (clk),
    .rst     (rst),
    .adv_i   (step_fire),
    .state_o (data_o),
    .fb_o    (fb_bit),
    .fresh_o (valid_o)
  );
endmodule

// File: rtl/lfsr_word_gen_chk.sv
module lfsr_word_gen_chk #(
  parameter int unsigned  W    = 256,
  parameter logic [W-1:0] SEED = '0,
  parameter logic [W-1:0] TAPS = '0
) (
  input logic         clk,
  input logic         rst,
  input logic         valid_i,
  input logic [W-1:0] data_o,
  input logic         valid_o,
  input logic         fb_bit
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1 / R8: reset reloads the seed and clears the flag.
  a_r1_seed_after_reset: assert property (@(posedge clk)
    rst_q |-> (data_o == SEED && !valid_o));

  a_r2_fb_to_msb: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> data_o[W-1] == $past(fb_bit));

  // R3: full single-step relation, shift plus conditional tap flips.
  a_r3_step_relation: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> data_o == (($past(data_o) >> 1)
                 ^ ({W{$past(data_o[0])}} & (TAPS | ({{(W-1){1'b0}}, 1'b1} << (W-1))))));

  a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);

  a_r5_valid_quiet: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !valid_o);

  a_r6_hold_word: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(data_o));
endmodule

bind lfsr_word_gen lfsr_word_gen_chk #(.W(W), .SEED(SEED), .TAPS(TAPS)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .valid_i (valid_i),
  .data_o  (data_o),
  .valid_o (valid_o),
  .fb_bit  (fb_bit)
);

// File: tb/lfsr_word_gen_tb_top.sv
`timescale 1ns/1ps
module lfsr_word_gen_tb_top;
  localparam logic [255:0] SEED_C =
    256'hDEADBEEFCAFEBABEFEEDFACEDECAFBAD1234567887654321ABCDEF010FEDCBA9;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         valid_i = 1'b0;
  logic [255:0] data_o;
  logic         valid_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [255:0] model;
  logic         prev_v, prev2_v;

  always #2 clk = ~clk;

  lfsr_word_gen dut_i (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid_i),
    .data_o  (data_o),
    .valid_o (valid_o)
  );

  // Reference model: rotate right, then flip the tap bits if the wrapped bit is 1.
  function automatic logic [255:0] ref_step(input logic [255:0] s);
    logic [255:0] r;
    r = {s[0], s[255:1]};
    if (s[0]) begin
      r[254] = ~r[254];
      r[252] = ~r[252];
      r[251] = ~r[251];
      r[246] = ~r[246];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Check the current cycle, then drive the next request.
  task automatic tick(input logic v);
    @(negedge clk);
    chk(prev_v && prev2_v ? "R7 data" : (prev_v ? "R4 data" : "R6 data"), data_o, model);
    chk(prev_v ? "R4 valid" : "R5 valid", {255'd0, valid_o}, {255'd0, prev_v});
    valid_i = v;
    if (v) model = ref_step(model);
    prev2_v = prev_v;
    prev_v  = v;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] one;
    logic [255:0] sh;
    int unused_seed;
    unused_seed = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    chk("R1 seed", data_o, SEED_C);
    chk("R1 valid", {255'd0, valid_o}, 256'd0);
    rst = 1'b0;
    model = SEED_C; prev_v = 1'b0; prev2_v = 1'b0;

    // Directed single step from the seed (seed LSB is 1).
    tick(1'b1);
    tick(1'b0);
    one = data_o;
    sh  = SEED_C >> 1;
    chk("R2 msb", {255'd0, one[255]}, {255'd0, SEED_C[0]});
    chk("R2 low shift", {10'd0, one[245:0]}, {10'd0, sh[245:0]});
    chk("R3 tap254", {255'd0, one[254]}, {255'd0, ~sh[254]});
    chk("R3 tap252", {255'd0, one[252]}, {255'd0, ~sh[252]});
    chk("R3 tap251", {255'd0, one[251]}, {255'd0, ~sh[251]});
    chk("R3 tap246", {255'd0, one[246]}, {255'd0, ~sh[246]});
    chk("R2 untouched", {253'd0, one[253], one[250:249]}, {253'd0, sh[253], sh[250:249]});

    // Back-to-back burst, then gaps.
    for (int i = 0; i < 12; i++) tick(1'b1);
    for (int i = 0; i < 3; i++) tick(1'b0);
    for (int i = 0; i < 10; i++) begin tick(1'b1); tick(1'b0); tick(1'b0); end
    for (int i = 0; i < 300; i++) tick(($urandom % 3) != 0);
    tick(1'b1);
    tick(1'b1);

    // R8: reset mid-burst wins over a request.
    @(negedge clk);
    rst = 1'b1; valid_i = 1'b1;
    @(negedge clk);
    chk("R8 seed", data_o, SEED_C);
    chk("R8 valid", {255'd0, valid_o}, 256'd0);
    rst = 1'b0; valid_i = 1'b0;
    model = SEED_C; prev_v = 1'b0; prev2_v = 1'b0;
    for (int i = 0; i < 40; i++) tick(1'b1);
    for (int i = 0; i < 200; i++) tick(($urandom % 2) != 0);
    tick(1'b0);
    tick(1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule